// File: doc/BRIEF.md
# Teletext Bit Request Inserter

This block decides on which video lines a teletext bitstream is inserted and runs the bit-by-bit handshake with an external teletext source during those lines. At the start of each line it looks up a per-field line mask. When the line is selected, it opens an insertion window. Inside the window it issues single-cycle request pulses on a fixed bit-period grid. A fractional accumulator derives that grid from the crystal clock, so the nominal teletext bit rate is met on average.

Each request solicits exactly one bit from the source. The source must present that bit on the serial input a programmable number of crystal clocks later. The block samples the bit at that moment and hands it on, with a one-cycle valid strobe, to the later modulation stage. The number of requests per window is fixed by the selected teletext standard and includes the clock run-in bits. As an alternative function, the request pin can carry a free-running half-rate copy of the crystal clock; in that mode no requests are issued and no bits are emitted.

Top module: `ttx_inserter`

## Requirements
- R1: While rst_n is low, and immediately after it is released, ttx_req, bit_out and bit_valid are 0.
- R2: A line_start pulse opens a window only if all of the following hold: line_valid is 1, clk_out_sel is 0, and the mask bit at position line_idx is set. The mask is mask_f0 when field_id is 0 and mask_f1 when field_id is 1. When no window is open, ttx_req (with clk_out_sel at 0) stays 0.
- R3: Let s be the clock edge that captures line_start. The n-th request of a window (n counted from 1) is raised by edge s + ceil(n*BIT_DEN/BIT_NUM) and is high for exactly one cycle. The defaults are BIT_NUM=37 and BIT_DEN=144.
- R4: The number of requests in a window depends on std_sel. The values are 0 gives 360, 1 gives 296, 2 gives 288, and 3 gives none (no window opens).
- R5: For a request raised by edge c, ttx_in is captured at edge c + req_delay + 1, where req_delay ranges from 0 to 15. bit_out then holds the captured value, and bit_valid is high for the one cycle after that edge.
- R6: Every request produces exactly one bit_valid strobe, and the strobes come in request order.
- R7: While clk_out_sel is 1, ttx_req inverts on every clock cycle, no window opens, and no request is issued.
- R8: A line_start that arrives during an open window ends that window. Requests already raised are still sampled, and the new line is then evaluated under R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each video line |
| line_valid | input | 1 | line_idx lies inside the maskable region |
| field_id | input | 1 | 0 = first field, 1 = second field |
| line_idx | input | 5 | Line index within the maskable region |
| mask_f0 | input | 32 | Line selection mask for the first field |
| mask_f1 | input | 32 | Line selection mask for the second field |
| std_sel | input | 2 | Teletext standard: 0, 1, 2 or 3 (off) |
| req_delay | input | 4 | Latency from request edge to data sample |
| clk_out_sel | input | 1 | 1 = request pin carries the half-rate clock |
| ttx_in | input | 1 | Serial teletext data from the source |
| ttx_req | output | 1 | Bit request pulse, or half-rate clock |
| bit_out | output | 1 | Last sampled teletext bit |
| bit_valid | output | 1 | One-cycle strobe marking a new bit_out |

## Verification
The hardest situation to reach from the ports is a window cut short by a fresh line_start. A request may be raised on the same edge that closes the window, and that request must still be sampled, while no further request may follow. The stimulus opens a full-length window and, about two hundred cycles later, pulses line_start on an unselected line. The expected request count is taken from the R3 grid up to that edge. The scoreboard then confirms that every request raised up to the cut still yields its bit, at the programmed latency and with the value the bench drove on ttx_in.

// File: rtl/ttx_pkg.sv
// Package: shared types and window lengths for the teletext inserter.
// Assumes the standard code is the 2-bit value presented on std_sel.
package ttx_pkg;

    typedef enum logic [1:0] {
        STD_WST625 = 2'd0,
        STD_WST525 = 2'd1,
        STD_NABTS  = 2'd2,
        STD_OFF    = 2'd3
    } ttx_std_e;

    localparam int CNT_W = 9;

    // Returns the number of bits (including run-in) for a standard; 0 = off.
    function automatic logic [CNT_W-1:0] window_bits(input ttx_std_e std);
        case (std)
            STD_WST625: window_bits = 9'd360;
            STD_WST525: window_bits = 9'd296;
            STD_NABTS:  window_bits = 9'd288;
            default:    window_bits = 9'd0;
        endcase
    endfunction

endpackage

// File: rtl/ttx_bit_timer.sv
// Bit-period grid generator. A fractional accumulator adds BIT_NUM per
// clock modulo BIT_DEN and flags a carry whenever it wraps, so carries
// occur BIT_NUM times per BIT_DEN clocks. restart zeroes the phase.
// Assumes 0 < BIT_NUM < BIT_DEN.
module ttx_bit_timer #(
    parameter int BIT_NUM = 37,
    parameter int BIT_DEN = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic carry
);
    localparam int ACC_W = $clog2(BIT_DEN) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(BIT_NUM);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(BIT_DEN - BIT_NUM);

    logic [ACC_W-1:0] acc;

    // Carry when adding one more step would reach the modulus.
    assign carry = (acc >= WRAP);

    // Advance the phase accumulator, wrapping on carry.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (restart) acc <= '0;
        else if (carry)   acc <= acc - WRAP;
        else              acc <= acc + STEP;
    end
endmodule

// File: rtl/ttx_window_ctrl.sv
// Insertion window control. On each line start it checks the field's
// line mask and opens a window whose length follows the standard. It
// issues one registered request pulse per timer carry until the window
// count is reached. Assumes line_start is a single-cycle strobe.
module ttx_window_ctrl
    import ttx_pkg::*;
#(
    parameter int MASK_N = 32,
    localparam int LINE_W = $clog2(MASK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              line_valid,
    input  logic              field_id,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [MASK_N-1:0] mask_f0,
    input  logic [MASK_N-1:0] mask_f1,
    input  ttx_std_e          std_sel,
    input  logic              block,
    input  logic              carry,
    output logic              active,
    output logic              req_q
);
    logic [CNT_W-1:0] len_now;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt;
    logic             mask_bit;
    logic             hit;
    logic             fire;

    // Select the mask bit of the current field and qualify the line.
    always_comb begin
        len_now  = window_bits(std_sel);
        mask_bit = field_id ? mask_f1[line_idx] : mask_f0[line_idx];
        hit      = line_valid && !block && (len_now != '0) && mask_bit;
        fire     = active && carry && !block;
    end

    // Open, count and close the insertion window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            len_q  <= '0;
        end else if (line_start) begin
            active <= hit;
            cnt    <= '0;
            len_q  <= len_now;
        end else if (fire) begin
            cnt <= cnt + 1'b1;
            if (cnt == len_q - 1'b1) active <= 1'b0;
        end
    end

    // Register the request pulse so the pin is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= fire;
    end
endmodule

// File: rtl/ttx_sample_pipe.sv
// Response sampler. Delays each request pulse through a shift chain and
// captures the serial input when the pulse reaches the tap chosen by
// delay_sel; tap 0 is the undelayed request. Assumes ttx_in is
// synchronous to clk.
module ttx_sample_pipe #(
    parameter int DLY_W = 4,
    localparam int DEPTH = (1 << DLY_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_q,
    input  logic [DLY_W-1:0] delay_sel,
    input  logic             ttx_in,
    output logic             bit_out,
    output logic             bit_valid
);
    logic [DEPTH-1:0] dly;
    logic [DEPTH:0]   taps;
    logic             tap;

    // Shift chain: each stage holds the request one cycle later.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage follows the live request.
            always_ff @(posedge clk) begin
                if (!rst_n) dly[0] <= 1'b0;
                else        dly[0] <= req_q;
            end
        end else begin : g_next
            // Later stages follow the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) dly[i] <= 1'b0;
                else        dly[i] <= dly[i-1];
            end
        end
    end

    // Pick the tap for the programmed latency.
    always_comb begin
        taps = {dly, req_q};
        tap  = taps[delay_sel];
    end

    // Capture the data bit and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= tap;
            if (tap) bit_out <= ttx_in;
        end
    end
endmodule

// File: rtl/ttx_inserter.sv
// Teletext bit request inserter (top). Combines the bit-grid timer,
// the window controller and the response sampler, and muxes the request
// pin between request pulses and a half-rate clock. Assumes all inputs
// are synchronous to the crystal clock.
module ttx_inserter
    import ttx_pkg::*;
#(
    parameter int MASK_N  = 32,
    parameter int DLY_W   = 4,
    parameter int BIT_NUM = 37,
    parameter int BIT_DEN = 144,
    localparam int LINE_W = $clog2(MASK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              line_valid,
    input  logic              field_id,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [MASK_N-1:0] mask_f0,
    input  logic [MASK_N-1:0] mask_f1,
    input  logic [1:0]        std_sel,
    input  logic [DLY_W-1:0]  req_delay,
    input  logic              clk_out_sel,
    input  logic              ttx_in,
    output logic              ttx_req,
    output logic              bit_out,
    output logic              bit_valid
);
    logic carry;
    logic win_active;
    logic req_q;
    logic half_q;

    ttx_bit_timer #(.BIT_NUM(BIT_NUM), .BIT_DEN(BIT_DEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (line_start),
        .carry   (carry)
    );

    ttx_window_ctrl #(.MASK_N(MASK_N)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_valid (line_valid),
        .field_id   (field_id),
        .line_idx   (line_idx),
        .mask_f0    (mask_f0),
        .mask_f1    (mask_f1),
        .std_sel    (ttx_std_e'(std_sel)),
        .block      (clk_out_sel),
        .carry      (carry),
        .active     (win_active),
        .req_q      (req_q)
    );

    ttx_sample_pipe #(.DLY_W(DLY_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_q     (req_q),
        .delay_sel (req_delay),
        .ttx_in    (ttx_in),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    // Half-rate clock: a toggle flop running from reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    // Pin function select.
    assign ttx_req = clk_out_sel ? half_q : req_q;
endmodule

// File: rtl/ttx_inserter_chk.sv
// Property checker for ttx_inserter, attached by bind below.
module ttx_inserter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_out_sel,
    input logic       line_start,
    input logic       line_valid,
    input logic [1:0] std_sel,
    input logic       ttx_req,
    input logic       win_active
);
    // R3
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ttx_req && !clk_out_sel) |=> (clk_out_sel || !ttx_req));

    // R7
    half_clock_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out_sel && $past(clk_out_sel)) |-> (ttx_req != $past(ttx_req)));

    // R2
    req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ttx_req && !clk_out_sel) |-> $past(win_active));

    // R2
    invalid_line_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !line_valid) |=> !win_active);

    // R4
    std_off_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && std_sel == 2'd3) |=> !win_active);
endmodule

bind ttx_inserter ttx_inserter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_out_sel (clk_out_sel),
    .line_start  (line_start),
    .line_valid  (line_valid),
    .std_sel     (std_sel),
    .ttx_req     (ttx_req),
    .win_active  (win_active)
);

// File: tb/test_ttx_inserter.sv
// Scoreboard bench: the responder drives ttx_in and queues each request,
// the monitor pops and compares every emitted bit.
module test_ttx_inserter;
    localparam int NUM = 37;
    localparam int DEN = 144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0, line_valid = 1'b0, field_id = 1'b0;
    logic [4:0]  line_idx = '0;
    logic [31:0] mask_f0 = '0, mask_f1 = '0;
    logic [1:0]  std_sel = '0;
    logic [3:0]  req_delay = '0;
    logic        clk_out_sel = 1'b0;
    logic        ttx_in = 1'b0;
    logic        ttx_req, bit_out, bit_valid;

    always #4 clk = ~clk;

    ttx_inserter i_ttx_inserter (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_valid(line_valid),
        .field_id(field_id), .line_idx(line_idx), .mask_f0(mask_f0), .mask_f1(mask_f1),
        .std_sel(std_sel), .req_delay(req_delay), .clk_out_sel(clk_out_sel),
        .ttx_in(ttx_in), .ttx_req(ttx_req), .bit_out(bit_out), .bit_valid(bit_valid)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    int req_total = 0;
    int win_s = 0, win_id = 0, seen_id = 0, n_seen = 0;
    int cur_d = 0;
    int pend[$];
    bit hist[4096];
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Responder and monitor: drive data, queue requests, compare bits.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ttx_in = lfsr[0];
        hist[cyc % 4096] = lfsr[0];
        if (rst_n) begin
            if (win_id != seen_id) begin
                seen_id = win_id;
                n_seen = 0;
            end
            if (!clk_out_sel && ttx_req) begin
                n_seen++;
                req_total++;
                pend.push_back(cyc);
                // R3 grid position of the n-th request
                check(cyc == win_s + (n_seen * DEN + NUM - 1) / NUM, "R3 request edge",
                      cyc - win_s, (n_seen * DEN + NUM - 1) / NUM);
            end
            if (bit_valid) begin
                if (pend.size() == 0) check(1'b0, "R6 strobe without request", 1, 0);
                else begin
                    int k;
                    k = pend.pop_front();
                    check(cyc == k + cur_d + 1, "R5 latency", cyc - k, cur_d + 1);
                    check(bit_out == hist[(k + cur_d) % 4096], "R5 sampled value",
                          int'(bit_out), int'(hist[(k + cur_d) % 4096]));
                end
            end
        end
    end

    function automatic int grid_count(input int len, input int span);
        int n = 0;
        for (int i = 1; i <= len; i++) if ((i * DEN + NUM - 1) / NUM <= span) n++;
        return n;
    endfunction

    task automatic pulse_line(input bit f, input int idx, input bit valid,
                              input int std, input int d);
        @(negedge clk);
        field_id = f; line_idx = 5'(idx); line_valid = valid;
        std_sel = 2'(std); req_delay = 4'(d); cur_d = d;
        line_start = 1'b1;
        win_s = cyc + 1;
        win_id++;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic run_line(input bit f, input int idx, input bit valid, input int std,
                            input int d, input int exp_cnt, input string rname);
        int c0;
        c0 = req_total;
        pulse_line(f, idx, valid, std, d);
        repeat (1600) @(negedge clk);
        check(req_total - c0 == exp_cnt, rname, req_total - c0, exp_cnt);
        check(pend.size() == 0, "R6 pending requests drained", pend.size(), 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, s1, s2, prev;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(ttx_req == 0 && bit_valid == 0 && bit_out == 0, "R1 outputs in reset",
              int'({ttx_req, bit_valid, bit_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 just after release
        check(ttx_req == 0 && bit_valid == 0 && bit_out == 0, "R1 outputs after reset",
              int'({ttx_req, bit_valid, bit_out}), 0);

        mask_f0 = 32'h0000_0021;  // lines 0 and 5 of field 0
        mask_f1 = 32'h8000_0000;  // line 31 of field 1
        // R2 R4 standard 0, selected line, delay 0
        run_line(1'b0, 5, 1'b1, 0, 0, 360, "R4 std0 window length");
        // R2 R4 R5 standard 1, field 1 mask, delay 7
        run_line(1'b1, 31, 1'b1, 1, 7, 296, "R4 std1 window length");
        // R4 R5 standard 2, longest delay
        run_line(1'b0, 0, 1'b1, 2, 15, 288, "R4 std2 window length");
        // R4 standard 3 opens nothing
        run_line(1'b0, 5, 1'b1, 3, 0, 0, "R4 std3 no window");
        // R2 field independence: line 5 only set in field-0 mask
        run_line(1'b1, 5, 1'b1, 0, 0, 0, "R2 other field mask");
        // R2 unmasked line
        run_line(1'b0, 6, 1'b1, 0, 0, 0, "R2 unselected line");
        // R2 line_valid low
        run_line(1'b0, 5, 1'b0, 0, 0, 0, "R2 line_valid low");

        // R8 window cut short by a new line start
        c0 = req_total;
        pulse_line(1'b0, 5, 1'b1, 0, 3);
        s1 = win_s;
        repeat (200) @(negedge clk);
        @(negedge clk);
        line_valid = 1'b0; line_start = 1'b1;
        s2 = cyc + 1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (1600) @(negedge clk);
        check(req_total - c0 == grid_count(360, s2 - s1), "R8 requests before cut",
              req_total - c0, grid_count(360, s2 - s1));
        check(pend.size() == 0, "R8 requests sampled after cut", pend.size(), 0);

        // R7 half-rate clock mode
        c0 = req_total;
        @(posedge clk); #2 clk_out_sel = 1'b1;
        pulse_line(1'b0, 5, 1'b1, 0, 0);
        prev = int'(ttx_req);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(int'(ttx_req) != prev, "R7 pin toggles", int'(ttx_req), 1 - prev);
            check(bit_valid == 0, "R7 no bits in clock mode", int'(bit_valid), 0);
            prev = int'(ttx_req);
        end
        @(posedge clk); #2 clk_out_sel = 1'b0;
        repeat (1600) @(negedge clk);
        check(req_total == c0, "R7 no requests from clock-mode line", req_total - c0, 0);

        // R2 R3 normal operation resumes with a fresh window
        run_line(1'b1, 31, 1'b1, 2, 1, 288, "R2 window after clock mode");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule